// File: doc/BRIEF.md
# Paced Sector Buffer Transfer Engine

This block is the outgoing-data side of a disc sector buffer controller. Software loads a byte count and issues a start. The engine then releases buffer bytes toward a destination at a rate set by a fixed number of time units per byte. Time is counted by a tick input that increments an internal time counter. The engine keeps its own position on that time line. On each evaluation it works out how many bytes the elapsed time pays for, and releases them only in whole groups of eight. A final group that covers everything still owed releases all of it in one step. At that moment the count register reads all ones, an active-low end flag goes low, and an interrupt line goes high if it is enabled.

Released bytes leave as a stream of buffer addresses with a valid/ready handshake. One address is transferred on each cycle in which `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_addr` holds its value. The engine grants no new group until the previous group has fully drained, so back-pressure slows the pacing but never loses a byte. A resync input lets an outside agent pull the engine's time position forward to its own time. A resync time behind the engine is ignored.

Top module: `sector_dma_engine`

## Requirements
- R1: After reset, `count_o` reads 16'hFFFF, `dte_n_o` is 1, `irq_o` is 0, `out_valid` is 0 and `out_addr` is 0.
- R2: A count loaded through `cnt_load`/`cnt_val` is the number of bytes minus one. A started transfer emits exactly `cnt_val`+1 addresses in total.
- R3: The allowance is the elapsed ticks since the engine position, divided by CPB (default 4) and rounded up. Only whole multiples of eight are granted. A smaller allowance grants nothing and leaves `count_o` unchanged.
- R4: When the rounded allowance is at least the bytes still owed, all owed bytes are granted in one step and the transfer ends.
- R5: When a transfer ends, `count_o` becomes 16'hFFFF, `dte_n_o` goes low, and `irq_o` goes high only if `ien` was 1. An accepted start sets `dte_n_o` to 1 and `irq_o` to 0.
- R6: A `resync` pulse moves the engine position to `resync_time` only if that time is ahead of the position. Otherwise the pulse has no effect.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr` holds its value.
- R8: `out_addr` advances by one on each handshake and wraps modulo 16384.
- R9: `start` and `cnt_load` are ignored while a transfer is running or granted bytes are still waiting to drain.
- R10: An accepted start sets the engine position to the current time. A non-final grant of N bytes advances the position by N*CPB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start a transfer (ignored while active) |
| cnt_load | input | 1 | Load `cnt_val` into the count (ignored while active) |
| cnt_val | input | 16 | Bytes to move minus one |
| ien | input | 1 | Transfer-end interrupt enable |
| tick | input | 1 | Advances engine time by one unit |
| resync | input | 1 | Pull the engine position forward to `resync_time` |
| resync_time | input | 32 | Time of the resyncing agent |
| out_ready | input | 1 | Destination accepts an address |
| out_valid | output | 1 | An address is offered |
| out_addr | output | 14 | Buffer address of the offered byte |
| count_o | output | 16 | Remaining count, minus one |
| dte_n_o | output | 1 | Transfer-end flag, active low |
| irq_o | output | 1 | Transfer-end interrupt |

## Verification
The hardest states to reach are the thresholds of the pacing arithmetic. One tick decides whether a group of eight is granted. That tick is the 29th after the position, so rounding up and rounding down give different results. The bench drives ticks one at a time, in exact counts, with idle gaps between bursts, and reads `count_o` at the last tick before a threshold and at the first tick after it. It places the second threshold where a wrong position advance would move it. Resync is shown by jumping the position ahead and then reaching the threshold exactly 29 ticks past the new position. The bench also runs one long transfer that carries the address past the 16 KiB wrap.

// File: rtl/sde_pkg.sv
package sde_pkg;
  // Round-up division of an elapsed time by a per-byte cost.
  function automatic logic [32:0] ceil_div(input logic [32:0] num, input logic [32:0] den);
    return (num + den - 33'd1) / den;
  endfunction
endpackage

// File: rtl/sde_pace.sv
module sde_pace #(
  parameter int TIME_W   = 32,
  parameter int CNT_W    = 16,
  parameter int CPB      = 4,
  parameter int GRP_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              eval_i,
  input  logic              resync_i,
  input  logic [TIME_W-1:0] resync_time_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              grant_o,
  output logic              flush_o,
  output logic [CNT_W:0]    gnum_o
);
  localparam int EW = TIME_W + 1;
  localparam logic [TIME_W-1:0] CPB_T = TIME_W'(CPB);
  localparam bit CPB_POW2 = (CPB & (CPB - 1)) == 0;
  localparam int CPB_SH = $clog2(CPB);

  logic [TIME_W-1:0] now_q, pos_q, diff, advance, pos_step, ahead;
  logic [EW-1:0]     elapsed, allowed, grouped, remain_e;
  logic [CNT_W:0]    remain;

  assign diff    = now_q - pos_q;
  assign elapsed = diff[TIME_W-1] ? '0 : {1'b0, diff};

  generate
    if (CPB_POW2) begin : g_shift
      assign allowed = (elapsed + EW'(CPB - 1)) >> CPB_SH;
    end else begin : g_div
      logic [32:0] q;
      assign q       = sde_pkg::ceil_div(33'(elapsed), 33'(CPB));
      assign allowed = EW'(q);
    end
  endgenerate

  assign grouped  = {allowed[EW-1:GRP_LOG2], {GRP_LOG2{1'b0}}};
  assign remain   = {1'b0, count_i} + (CNT_W+1)'(1);
  assign remain_e = EW'(remain);

  always_comb begin
    grant_o = 1'b0;
    flush_o = 1'b0;
    gnum_o  = '0;
    if (eval_i) begin
      if (grouped >= remain_e) begin
        grant_o = 1'b1;
        flush_o = 1'b1;
        gnum_o  = remain;
      end else if (grouped != '0) begin
        grant_o = 1'b1;
        gnum_o  = grouped[CNT_W:0];
      end
    end
  end

  assign advance  = TIME_W'(gnum_o) * CPB_T;
  assign pos_step = grant_o ? pos_q + advance : pos_q;
  assign ahead    = resync_time_i - pos_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
      pos_q <= '0;
    end else begin
      if (tick_i) now_q <= now_q + TIME_W'(1);
      if (start_i)
        pos_q <= now_q;
      else if (resync_i && !ahead[TIME_W-1] && ahead != '0)
        pos_q <= resync_time_i;
      else
        pos_q <= pos_step;
    end
  end
endmodule

// File: rtl/sde_track.sv
module sde_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             start_i,
  input  logic             grant_i,
  input  logic             flush_i,
  input  logic [CNT_W:0]   gnum_i,
  input  logic             ien_i,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             dte_n_o,
  output logic             irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '1;
      busy_o  <= 1'b0;
      dte_n_o <= 1'b1;
      irq_o   <= 1'b0;
    end else begin
      if (load_i) count_o <= load_val_i;
      if (start_i) begin
        busy_o  <= 1'b1;
        dte_n_o <= 1'b1;
        irq_o   <= 1'b0;
      end
      if (grant_i) begin
        if (flush_i) begin
          count_o <= '1;
          busy_o  <= 1'b0;
          dte_n_o <= 1'b0;
          irq_o   <= ien_i;
        end else begin
          count_o <= count_o - gnum_i[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/sde_emit.sv
module sde_emit #(
  parameter int CNT_W = 16,
  parameter int AW    = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [CNT_W:0] num_i,
  input  logic           ready_i,
  output logic           valid_o,
  output logic [AW-1:0]  addr_o
);
  logic [CNT_W:0] pend_q;

  assign valid_o = pend_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      addr_o <= '0;
    end else if (load_i) begin
      pend_q <= num_i;
    end else if (valid_o && ready_i) begin
      pend_q <= pend_q - (CNT_W+1)'(1);
      addr_o <= addr_o + AW'(1);
    end
  end
endmodule

// File: rtl/sector_dma_engine.sv
module sector_dma_engine #(
  parameter int CNT_W    = 16,
  parameter int TIME_W   = 32,
  parameter int AW       = 14,
  parameter int CPB      = 4,
  parameter int GRP_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              ien,
  input  logic              tick,
  input  logic              resync,
  input  logic [TIME_W-1:0] resync_time,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [AW-1:0]     out_addr,
  output logic [CNT_W-1:0]  count_o,
  output logic              dte_n_o,
  output logic              irq_o
);
  logic           busy, active, start_acc, load_acc, eval_en;
  logic           grant, flush;
  logic [CNT_W:0] gnum;

  assign active    = busy || out_valid;
  assign start_acc = start && !active;
  assign load_acc  = cnt_load && !active;
  assign eval_en   = busy && !out_valid;

  sde_pace #(.TIME_W(TIME_W), .CNT_W(CNT_W), .CPB(CPB), .GRP_LOG2(GRP_LOG2)) u_pace (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start_acc), .eval_i(eval_en),
    .resync_i(resync), .resync_time_i(resync_time), .count_i(count_o),
    .grant_o(grant), .flush_o(flush), .gnum_o(gnum)
  );

  sde_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .load_i(load_acc), .load_val_i(cnt_val),
    .start_i(start_acc), .grant_i(grant), .flush_i(flush), .gnum_i(gnum),
    .ien_i(ien), .count_o(count_o), .busy_o(busy), .dte_n_o(dte_n_o), .irq_o(irq_o)
  );

  sde_emit #(.CNT_W(CNT_W), .AW(AW)) u_emit (
    .clk(clk), .rst_n(rst_n), .load_i(grant), .num_i(gnum), .ready_i(out_ready),
    .valid_o(out_valid), .addr_o(out_addr)
  );
endmodule

// File: rtl/sector_dma_engine_chk.sv
module sector_dma_engine_chk #(
  parameter int CNT_W = 16,
  parameter int AW    = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ien,
  input logic           out_valid,
  input logic           out_ready,
  input logic [AW-1:0]  out_addr,
  input logic [CNT_W-1:0] count_o,
  input logic           dte_n_o,
  input logic           irq_o,
  input logic           busy,
  input logic           grant,
  input logic           flush,
  input logic [CNT_W:0] gnum
);
  a_r3_whole_groups: assert property (@(posedge clk) disable iff (!rst_n)
    grant && !flush |-> gnum[2:0] == 3'd0 && gnum != '0);

  a_r4_flush_ends: assert property (@(posedge clk) disable iff (!rst_n)
    grant && flush |=> !busy && !dte_n_o);

  a_r5_end_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dte_n_o) |-> count_o == '1);

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ien));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> out_addr == $past(out_addr) + AW'(1));
endmodule

bind sector_dma_engine sector_dma_engine_chk #(.CNT_W(CNT_W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ien(ien), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .count_o(count_o), .dte_n_o(dte_n_o), .irq_o(irq_o),
  .busy(busy), .grant(grant), .flush(flush), .gnum(gnum)
);

// File: tb/sector_dma_engine_tb_top.sv
`timescale 1ns/1ps
module sector_dma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, cnt_load = 1'b0, ien = 1'b0, tick = 1'b0, resync = 1'b0;
  logic [15:0] cnt_val = '0;
  logic [31:0] resync_time = '0;
  logic        out_ready = 1'b1;
  logic        out_valid, dte_n_o, irq_o;
  logic [13:0] out_addr;
  logic [15:0] count_o;

  int total = 0, bad = 0;
  int bench_now = 0;
  int next_addr = 0;
  logic [13:0] exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  sector_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .ien(ien), .tick(tick), .resync(resync), .resync_time(resync_time),
    .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
    .count_o(count_o), .dte_n_o(dte_n_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    bench_now += n;
  endtask

  // Driver: starts a transfer and pushes the addresses it must produce.
  task automatic launch(input int cnt, input bit en);
    cnt_val = 16'(cnt); cnt_load = 1'b1; start = 1'b1; ien = en;
    for (int i = 0; i <= cnt; i++) begin
      exp_q.push_back(14'(next_addr));
      next_addr = (next_addr + 1) % 16384;
    end
    @(negedge clk);
    cnt_load = 1'b0; start = 1'b0;
  endtask

  task automatic pulse_resync(input int t);
    resync = 1'b1; resync_time = 32'(t);
    @(negedge clk);
    resync = 1'b0;
  endtask

  // Monitor: pops the scoreboard on every handshake.
  always begin
    @(negedge clk);
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 actual=extra byte addr %0h expected=none", out_addr);
      end else begin
        check("R8 address order", out_addr, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 count", count_o, 16'hFFFF);
    check("R1 dte_n", dte_n_o, 1);
    check("R1 irq", irq_o, 0);
    check("R1 valid", out_valid, 0);
    check("R1 addr", out_addr, 0);
    rst_n = 1'b1;
    idle(2);

    // A: 20 bytes, interrupt enabled
    launch(19, 1'b1);
    check("R5 start sets dte_n", dte_n_o, 1);
    check("R2 count loaded", count_o, 19);
    do_ticks(20);
    start = 1'b1; cnt_load = 1'b1; cnt_val = 16'd100;
    @(negedge clk);
    start = 1'b0; cnt_load = 1'b0;
    do_ticks(8);
    idle(2);
    check("R9 load ignored, R3 28 ticks grant none", count_o, 19);
    check("R3 no byte before group", out_valid, 0);
    do_ticks(1);
    idle(12);
    check("R3 rounded-up allowance grants 8 (R9 start ignored)", count_o, 11);
    do_ticks(31);
    idle(3);
    check("R10 position advanced by 8*CPB", count_o, 11);
    do_ticks(1);
    idle(12);
    check("R10 second group on time", count_o, 3);
    do_ticks(3);
    do_ticks(4);
    idle(3);
    check("R3 remainder waits", count_o, 3);
    check("R3 still running", dte_n_o, 1);
    do_ticks(30);
    idle(12);
    check("R4 flush count all ones", count_o, 16'hFFFF);
    check("R5 dte_n low at end", dte_n_o, 0);
    check("R5 irq with ien", irq_o, 1);

    // B: 3 bytes, interrupt disabled, back-pressure
    out_ready = 1'b0;
    launch(2, 1'b0);
    check("R5 start clears irq", irq_o, 0);
    do_ticks(29);
    idle(3);
    check("R4 short flush count", count_o, 16'hFFFF);
    check("R5 irq gated by ien", irq_o, 0);
    check("R7 valid under stall", out_valid, 1);
    check("R7 addr under stall", out_addr, 20);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle(4);
    check("R9 start ignored while draining", dte_n_o, 0);
    check("R7 addr held", out_addr, 20);
    out_ready = 1'b1;
    idle(10);
    check("R2 stream drained", out_valid, 0);

    // C: 16 bytes with resync
    launch(15, 1'b1);
    pulse_resync(bench_now + 100);
    do_ticks(50);
    idle(3);
    check("R6 resync ahead holds back", count_o, 15);
    pulse_resync(bench_now - 50);
    do_ticks(78);
    idle(3);
    check("R6 behind resync ignored", count_o, 15);
    do_ticks(1);
    idle(12);
    check("R6 group 29 ticks past new position", count_o, 7);
    do_ticks(40);
    idle(12);
    check("R4 exact flush", count_o, 16'hFFFF);
    check("R5 end irq", irq_o, 1);

    // D: long transfer crossing the address wrap
    launch(16348, 1'b1);
    do_ticks(16349 * 4 + 64);
    idle(20);
    check("R4 long flush", count_o, 16'hFFFF);
    check("R8 wrapped address", out_addr, 4);
    check("R2 all bytes emitted", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule